// File: doc/BRIEF.md
# Asynchronous Serial Transmit Framer

This block turns parallel bytes into asynchronous serial frames on a single output line. A producer presents a byte with `in_valid`. The framer accepts the byte when `in_ready` is high and then sends one frame. The frame is a low start bit, the data bits least significant first, an optional parity bit and a high stop period. Bit timing comes from `baud_tick`, an enable pulse that runs at sixteen times the bit rate. Each bit lasts a fixed number of these pulses, so the framer never advances in a cycle with no tick.

The format of each frame is set by an 8-bit control word on `line_ctrl`:

- **Bits 1:0:** character length.
- **Bit 2:** stop length.
- **Bit 3:** parity enable.
- **Bit 4:** even parity.
- **Bit 5:** stick parity.
- **Bit 6:** break control.
- **Bit 7:** not used.

The format fields are captured at the moment a byte is accepted. Break control acts on the line at once and does not wait for a frame.

The controller is a five-state machine:

- **IDLE:** waiting for a byte; the line rests high.
- **START:** drives the start bit.
- **DATA:** shifts out the data bits.
- **PARITY:** sends the parity bit.
- **STOP:** holds the line high for the stop period.

The state transitions are:

- **IDLE→START:** a byte is accepted.
- **START→DATA:** the start bit is complete.
- **DATA→DATA:** a data bit is complete and more data bits remain.
- **DATA→PARITY:** the last data bit is complete and parity is enabled.
- **DATA→STOP:** the last data bit is complete and parity is disabled.
- **PARITY→STOP:** the parity bit is complete.
- **STOP→IDLE:** the stop period is complete.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` is high, `busy` is low, `in_ready` is high and `idle` is high.
- R2: `in_ready` is high exactly when no frame is in progress. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. From the next cycle `busy` is high, `in_ready` is low and `txd` carries the low start bit.
- R3: `line_ctrl[1:0]` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The data bits follow the start bit, least significant bit first. Bits of `in_data` above the character length are not sent.
- R4: The start, data and parity bits each last 16 `baud_tick` pulses. Cycles with `baud_tick` low do not advance the frame.
- R5: When `line_ctrl[3]` is set and `line_ctrl[5]` is clear, a parity bit follows the data. With `line_ctrl[4]` set it equals the XOR of the sent data bits (even parity); with `line_ctrl[4]` clear it is the inverse of that XOR (odd parity). With `line_ctrl[3]` clear no parity bit is sent.
- R6: When `line_ctrl[3]` and `line_ctrl[5]` are both set, the parity bit is the constant NOT `line_ctrl[4]`, whatever the data.
- R7: The stop period is high. With `line_ctrl[2]` clear it lasts 16 ticks. With `line_ctrl[2]` set it lasts 24 ticks for 5-bit characters and 32 ticks for all other lengths. `busy` falls in the cycle after the last stop tick.
- R8: While `line_ctrl[6]` is set, `txd` is low, both in IDLE and within a frame. Break changes neither the frame timing nor the moment `busy` falls.
- R9: `line_ctrl[5:0]` and `in_data` are sampled only at acceptance. Changes to them during a frame do not alter that frame.
- R10: `idle` is high only when no frame is in progress and `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| line_ctrl | input | 8 | Frame format and break control word |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | `in_data` holds a byte to send |
| in_ready | output | 1 | Framer can accept a byte |
| txd | output | 1 | Serial output line, high at rest |
| busy | output | 1 | A frame is in progress |
| idle | output | 1 | No frame in progress and no byte pending |

## Verification
The hardest case to reach from the ports is a frame whose format inputs change while it is still being sent.

The framer captures the format fields on acceptance, so a design that reads the live word would still send correct frames whenever the word is held steady. The bench therefore inverts `line_ctrl[5:0]` and `in_data` right after acceptance in many frames. It does this across the full sweep of all 64 format codes, so a frame that follows the new word shows up as a wrong bit or a wrong length.

The bench also holds `baud_tick` low for stretches in the middle of bits. This shows up any counter that advances on the clock rather than on the tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } tx_state_e;

    typedef struct packed {
        logic       stick;
        logic       even;
        logic       par_en;
        logic       long_stop;
        logic [1:0] len_code;
    } frame_fmt_t;

    function automatic frame_fmt_t decode_fmt(input logic [5:0] w);
        frame_fmt_t f;
        f.len_code  = w[1:0];
        f.long_stop = w[2];
        f.par_en    = w[3];
        f.even      = w[4];
        f.stick     = w[5];
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_tickcnt.sv
module uart_tx_tickcnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt;

    assign last = tick && !clear && (cnt == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            if (last) cnt <= '0;
            else      cnt <= cnt + CW'(1);
        end
    end

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear) |-> (cnt < limit));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  frame_fmt_t    load_fmt,
    input  logic          shift,
    output logic          lsb,
    output logic          par_bit
);
    logic [DW-1:0] data_q;
    logic [DW-1:0] mask;
    logic          sum;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < 5 + int'(load_fmt.len_code));
        end
        sum = ^(load_data & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            par_bit <= 1'b0;
        end else if (load) begin
            data_q  <= load_data;
            if (load_fmt.stick) par_bit <= ~load_fmt.even;
            else if (load_fmt.even) par_bit <= sum;
            else par_bit <= ~sum;
        end else if (shift) begin
            data_q <= data_q >> 1;
        end
    end

    assign lsb = data_q[0];

    assert_shift_lsb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (data_q == ($past(data_q) >> 1)));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_tx_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       bit_done,
    input  frame_fmt_t fmt,
    output tx_state_e  state,
    output logic       shift
);
    tx_state_e       state_d;
    logic [IW-1:0]   bidx;
    logic [IW-1:0]   last_idx;

    assign last_idx = IW'(fmt.len_code) + IW'(4);

    always_comb begin
        state_d = state;
        shift   = 1'b0;
        unique case (state)
            S_IDLE:   if (start_req) state_d = S_START;
            S_START:  if (bit_done) state_d = S_DATA;
            S_DATA: begin
                if (bit_done) begin
                    shift = 1'b1;
                    if (bidx == last_idx) state_d = fmt.par_en ? S_PARITY : S_STOP;
                end
            end
            S_PARITY: if (bit_done) state_d = S_STOP;
            S_STOP:   if (bit_done) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        bidx <= '0;
        else if (state != S_DATA)          bidx <= '0;
        else if (bit_done)                 bidx <= bidx + IW'(1);
    end

    assert_stop_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP && !bit_done) |=> (state == S_STOP));

    assert_no_skip_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && state_d != S_IDLE) |=> (state == S_START));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [7:0]        line_ctrl,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              txd,
    output logic              busy,
    output logic              idle
);
    localparam int STOP_LONG5 = TICKS_PER_BIT + TICKS_PER_BIT / 2;
    localparam int STOP_LONG  = 2 * TICKS_PER_BIT;
    localparam int CW         = $clog2(STOP_LONG + 1);
    localparam int IW         = $clog2(DATA_W);

    tx_state_e     state;
    frame_fmt_t    fmt_q;
    logic          accept;
    logic          bit_done;
    logic          shift;
    logic          lsb;
    logic          par_bit;
    logic          line_bit;
    logic [CW-1:0] limit;
    logic          unused_ctrl7;

    assign unused_ctrl7 = line_ctrl[7];
    assign accept       = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fmt_q <= '0;
        else if (accept) fmt_q <= decode_fmt(line_ctrl[5:0]);
    end

    always_comb begin
        if (state == S_STOP && fmt_q.long_stop)
            limit = (fmt_q.len_code == 2'b00) ? CW'(STOP_LONG5) : CW'(STOP_LONG);
        else
            limit = CW'(TICKS_PER_BIT);
    end

    uart_tx_ctrl #(.IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (in_valid),
        .bit_done  (bit_done),
        .fmt       (fmt_q),
        .state     (state),
        .shift     (shift)
    );

    uart_tx_tickcnt #(.CW(CW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == S_IDLE),
        .tick  (baud_tick),
        .limit (limit),
        .last  (bit_done)
    );

    uart_tx_shifter #(.DW(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (in_data),
        .load_fmt  (decode_fmt(line_ctrl[5:0])),
        .shift     (shift),
        .lsb       (lsb),
        .par_bit   (par_bit)
    );

    always_comb begin
        unique case (state)
            S_IDLE:   line_bit = 1'b1;
            S_START:  line_bit = 1'b0;
            S_DATA:   line_bit = lsb;
            S_PARITY: line_bit = par_bit;
            S_STOP:   line_bit = 1'b1;
            default:  line_bit = 1'b1;
        endcase
        txd      = line_bit && !line_ctrl[6];
        busy     = (state != S_IDLE);
        in_ready = (state == S_IDLE);
        idle     = (state == S_IDLE) && !in_valid;
    end

    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !in_ready && state == S_START));

    assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctrl[6] |-> !txd);

    assert_fmt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(fmt_q));

    assert_idle_meaning_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!busy && !in_valid));

endmodule

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] line_ctrl = 8'h00;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready, txd, busy, idle;
    int         n_vec = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    uart_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctrl(line_ctrl),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .txd(txd), .busy(busy), .idle(idle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends one frame and compares txd in every cycle against a computed bit list.
    task automatic send_frame(input logic [7:0] d, input logic [5:0] c, input int gap,
                              input bit brk, input bit scramble);
        logic exp_b[12];
        int   len_t[12];
        string tag[12];
        int   n = 0;
        int   nb = int'(c[1:0]) + 5;
        logic s = 1'b0;
        exp_b[n] = 1'b0; len_t[n] = 16; tag[n] = "R3 start"; n++;
        for (int i = 0; i < nb; i++) begin
            exp_b[n] = d[i]; len_t[n] = 16; tag[n] = "R3 data"; n++;
            s ^= d[i];
        end
        if (c[3]) begin
            exp_b[n] = c[5] ? ~c[4] : (c[4] ? s : ~s);
            len_t[n] = 16; tag[n] = c[5] ? "R6 stick parity" : "R5 parity"; n++;
        end
        exp_b[n] = 1'b1;
        len_t[n] = c[2] ? ((nb == 5) ? 24 : 32) : 16;
        tag[n] = "R7 stop"; n++;

        @(negedge clk);
        line_ctrl = {1'b0, brk, c};
        in_data   = d;
        in_valid  = 1'b1;
        baud_tick = 1'b0;
        #1;
        check(in_ready && !idle, "R10 idle low while byte pending", idle, 0);
        @(posedge clk);
        for (int b = 0; b < n; b++) begin
            bit ok = 1'b1;
            int act = 0;
            logic want = brk ? 1'b0 : exp_b[b];
            for (int t = 0; t < len_t[b]; t++) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0; baud_tick = 1'b0;
                    if (scramble) begin line_ctrl[5:0] = ~c; in_data = ~d; end
                    if (txd !== want || busy !== 1'b1) begin ok = 1'b0; act = txd; end
                    @(posedge clk);
                end
                @(negedge clk);
                in_valid = 1'b0; baud_tick = 1'b1;
                if (scramble) begin line_ctrl[5:0] = ~c; in_data = ~d; end
                if (txd !== want || busy !== 1'b1) begin ok = 1'b0; act = txd; end
                if (b == 0 && t == 0)
                    check(busy && !in_ready, "R2 busy and not ready after accept", in_ready, 0);
                @(posedge clk);
            end
            check(ok, gap > 0 ? {tag[b], " R4 gapped"} : (scramble ? {tag[b], " R9"} :
                  (brk ? {tag[b], " R8"} : tag[b])), act, want);
        end
        @(negedge clk);
        baud_tick = 1'b0;
        line_ctrl = 8'h00;
        #1;
        check(!busy && in_ready && idle, "R7 R10 frame ends on last stop tick", busy, 0);
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(txd && !busy && in_ready && idle, "R1 reset state", {txd, busy, in_ready, idle}, 4'b1011);

        // Break on an idle line.
        @(negedge clk);
        line_ctrl = 8'h40;
        #1;
        check(txd == 1'b0, "R8 break in idle", txd, 0);
        @(negedge clk);
        line_ctrl = 8'h00;
        #1;
        check(txd == 1'b1, "R8 break released", txd, 1);

        // Full sweep of the format codes.
        for (int c = 0; c < 64; c++) begin
            send_frame(8'hA5, 6'(c), 0, 1'b0, 1'b0);
            send_frame(8'(c * 37 + 11), 6'(c), 0, 1'b0, 1'b1);
            send_frame(8'h3C ^ 8'(c), 6'(c), 0, 1'b0, (c % 2) == 1);
        end

        // Ticks with gaps between them.
        send_frame(8'h96, 6'b011011, 2, 1'b0, 1'b0);
        send_frame(8'h21, 6'b000100, 1, 1'b0, 1'b1);

        // Break held through a whole frame keeps the timing.
        send_frame(8'h5A, 6'b001111, 0, 1'b1, 1'b0);
        send_frame(8'h0F, 6'b110100, 0, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule